// File: doc/BRIEF.md
# Majority-Logic Compute Memory Controller

This block is a small bit-array memory whose read path also computes logic. Each memory cycle applies one operation code to a row and column address. A plain read senses one cell. A majority read activates three consecutive rows at once, at a reduced read level, and senses whether at least two of the three cells in the column hold 1. A separate control picks the complemented output of the sense amplifier, which gives NOT and inverted majority in the same single cycle. Writes drive a set pulse on the bitline to store 1, or a reset pulse on the source line to store 0. A behavioural bit-array stands in for the resistive cells: a stored 1 is the low-resistance state and a stored 0 the high-resistance state.

Columns are grouped so that eight bitlines share one sense lane. A different group can carry out its own operation in the same cycle. A built-in sequencer uses this to run a one-bit full adder as six memory cycles across two groups. Before the start command, software places A, B and Cin in rows 0, 1 and 2 of column 0 and of column 8. The sequencer uses those two columns as scratch space, overwrites them, and returns sum and carry with a done pulse.

Top module: `imc_majority_ctrl`

## Requirements
- R1: Opcode 1 (read) activates exactly one row at the full read level with sensing enabled. The stored bit of (row_i, col_i) appears on sense_o in the cycle after the operation is applied.
- R2: Opcode 2 (inverted read) behaves like opcode 1, except that sense_o shows the complement of the stored bit.
- R3: Opcode 3 (majority) activates rows row_i, row_i+1 and row_i+2, taken modulo the row count, at the reduced read level. sense_o is 1 in the next cycle when at least two of those three cells in column col_i hold 1.
- R4: Opcode 4 (inverted majority) selects the same three rows as opcode 3 and presents the complement of the majority.
- R5: Opcode 5 stores 1 and opcode 6 stores 0. Opcode 7 stores wdata_i. A write activates one row and leaves sensing disabled. It drives the bitline pulse when storing 1 and the source-line pulse when storing 0, and never both at once. Opcode 0 does nothing.
- R6: sense_o is registered. It keeps its value through writes and idle cycles, and it shows the sense lane (col_i / 8) of the last sensing operation.
- R7: After start_i, sum_o and carry_o equal the binary sum of the A, B and Cin operands for all eight input combinations.
- R8: busy_o is high for exactly six cycles, starting in the cycle after start_i is taken. done_o is high for one cycle, six cycles after the accepting edge. At that point busy_o is low, and sum_o and carry_o hold until the next run.
- R9: Operations and start commands are ignored while busy_o is high. An operation applied in the same cycle as an accepted start_i is also ignored.
- R10: After reset, sense_o, busy_o, done_o, sum_o and carry_o are 0 and every cell reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code, 0 to 7 |
| row_i | input | ROW_W (4) | Row address; first of three rows for majority |
| col_i | input | COL_W (4) | Column address; upper bits select the sense lane |
| wdata_i | input | 1 | Data bit for opcode 7 |
| start_i | input | 1 | Start the full-adder sequence |
| sense_o | output | 1 | Registered sense result |
| busy_o | output | 1 | Adder sequence running |
| done_o | output | 1 | One-cycle pulse when the adder result is ready |
| sum_o | output | 1 | Adder sum |
| carry_o | output | 1 | Adder carry-out |

## Verification
A sensing operation that is driven in one cycle shows its result on sense_o one clock edge later. The bench therefore queues that expectation with a due cycle one beyond the cycle in which the operation was driven. A start applied in cycle n is expected to give busy in cycles n+1 to n+6, and done, sum and carry in cycle n+7. In cycle n+8, done is expected low and the results are expected to hold. The monitor compares each queued item only in its due cycle and samples on the falling edge. Writes that are ignored during a run are checked afterwards by reading the cells they targeted.

// File: rtl/imc_pkg.sv
package imc_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_READ = 3'd1,
        OP_NOT  = 3'd2,
        OP_MAJ  = 3'd3,
        OP_NMAJ = 3'd4,
        OP_SET  = 3'd5,
        OP_CLR  = 3'd6,
        OP_WRD  = 3'd7
    } imc_op_e;

    typedef enum logic [1:0] {
        LVL_OFF   = 2'd0,
        LVL_FULL  = 2'd1,
        LVL_THIRD = 2'd2
    } rd_level_e;

    typedef struct packed {
        logic      sense_en;
        logic      maj;
        logic      inv;
        logic      bl_pulse;
        logic      sl_pulse;
        rd_level_e level;
    } imc_ctrl_t;

    localparam int ADD_STEPS = 6;

    function automatic imc_ctrl_t imc_decode(imc_op_e op, logic wd);
        imc_ctrl_t c;
        c = '{sense_en: 1'b0, maj: 1'b0, inv: 1'b0, bl_pulse: 1'b0,
              sl_pulse: 1'b0, level: LVL_OFF};
        case (op)
            OP_READ: begin c.sense_en = 1'b1; c.level = LVL_FULL; end
            OP_NOT:  begin c.sense_en = 1'b1; c.level = LVL_FULL; c.inv = 1'b1; end
            OP_MAJ:  begin c.sense_en = 1'b1; c.level = LVL_THIRD; c.maj = 1'b1; end
            OP_NMAJ: begin
                c.sense_en = 1'b1; c.level = LVL_THIRD; c.maj = 1'b1; c.inv = 1'b1;
            end
            OP_SET:  c.bl_pulse = 1'b1;
            OP_CLR:  c.sl_pulse = 1'b1;
            OP_WRD:  begin c.bl_pulse = wd; c.sl_pulse = ~wd; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/imc_op_decoder.sv
module imc_op_decoder
    import imc_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  imc_op_e          op,
    input  logic [ROW_W-1:0] row,
    input  logic             wdata,
    output imc_ctrl_t        ctrl,
    output logic [ROWS-1:0]  wl
);
    always_comb begin
        ctrl = imc_decode(op, wdata);
        wl   = '0;
        if (op != OP_NOP) begin
            for (int r = 0; r < ROWS; r++) begin
                // distance of row r above the addressed row, wrapping
                if (((r - int'(row) + ROWS) % ROWS) == 0)
                    wl[r] = 1'b1;
                else if (ctrl.maj && (((r - int'(row) + ROWS) % ROWS) < 3))
                    wl[r] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/imc_cell_array.sv
module imc_cell_array
    import imc_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int BPS   = 8,
    parameter int LANES = COLS / BPS,
    parameter int LCW   = $clog2(BPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROWS-1:0]  wl    [LANES],
    input  logic [LCW-1:0]   col   [LANES],
    input  logic [LANES-1:0] set_p,
    input  logic [LANES-1:0] clr_p,
    input  rd_level_e        level [LANES],
    output logic [LANES-1:0] raw
);
    localparam int CW = $clog2(ROWS + 1);

    logic [COLS-1:0] cells [ROWS];
    logic [CW-1:0]   cnt   [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                for (int r = 0; r < ROWS; r++) begin
                    if (wl[l][r] && set_p[l])
                        cells[r][l*BPS + int'(col[l])] <= 1'b1;
                    else if (wl[l][r] && clr_p[l])
                        cells[r][l*BPS + int'(col[l])] <= 1'b0;
                end
            end
        end
    end

    // Column current model: count of low-resistance cells on active rows
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            cnt[l] = '0;
            for (int r = 0; r < ROWS; r++)
                cnt[l] = cnt[l] + CW'(wl[l][r] & cells[r][l*BPS + int'(col[l])]);
            case (level[l])
                LVL_FULL:  raw[l] = (cnt[l] >= CW'(1));
                LVL_THIRD: raw[l] = (cnt[l] >= CW'(2));
                default:   raw[l] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/imc_sense_lane.sv
module imc_sense_lane (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic inv,
    input  logic raw,
    output logic d,
    output logic q
);
    // true / complement output select ahead of the latch
    assign d = inv ? ~raw : raw;

    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/imc_add_seq.sv
module imc_add_seq
    import imc_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int BPS    = 8,
    parameter int LANES  = 2,
    parameter int X_LANE = 0,
    parameter int Y_LANE = 1,
    parameter int X_LOC  = 0,
    parameter int Y_LOC  = 0,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int LCW    = $clog2(BPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sa_x_q,
    input  logic             sa_y_q,
    input  logic             sa_x_d,
    input  logic             sa_y_d,
    output imc_op_e          op  [LANES],
    output logic [ROW_W-1:0] row [LANES],
    output logic [LCW-1:0]   col [LANES],
    output logic             wd  [LANES],
    output logic             busy,
    output logic             done,
    output logic             sum,
    output logic             carry
);
    logic [2:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            sum   <= 1'b0;
            carry <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy <= 1'b1;
                step <= 3'd1;
            end else if (busy) begin
                if (step == 3'(ADD_STEPS)) begin
                    busy  <= 1'b0;
                    step  <= '0;
                    done  <= 1'b1;
                    sum   <= sa_x_d;
                    carry <= sa_y_d;
                end else begin
                    step <= step + 3'd1;
                end
            end
        end
    end

    // Schedule: X column holds A,B,Cin; Y column holds a copy
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            op[l]  = OP_NOP;
            row[l] = '0;
            col[l] = '0;
            wd[l]  = 1'b0;
        end
        col[X_LANE] = LCW'(X_LOC);
        col[Y_LANE] = LCW'(Y_LOC);
        case (step)
            3'd1: begin op[Y_LANE] = OP_NOT; row[Y_LANE] = ROW_W'(2); end
            3'd2: begin
                op[Y_LANE] = OP_WRD; row[Y_LANE] = ROW_W'(2); wd[Y_LANE] = sa_y_q;
            end
            3'd3: begin op[X_LANE] = OP_NMAJ; op[Y_LANE] = OP_MAJ; end
            3'd4: begin
                op[X_LANE] = OP_WRD; wd[X_LANE] = sa_x_q;
                op[Y_LANE] = OP_WRD; wd[Y_LANE] = sa_x_q;
            end
            3'd5: begin
                op[X_LANE] = OP_WRD; row[X_LANE] = ROW_W'(1); wd[X_LANE] = sa_y_q;
            end
            3'd6: begin op[X_LANE] = OP_MAJ; op[Y_LANE] = OP_NOT; end
            default: ;
        endcase
    end
endmodule

// File: rtl/imc_majority_ctrl.sv
module imc_majority_ctrl
    import imc_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 16,
    parameter int BPS    = 8,
    parameter int ADD_CX = 0,
    parameter int ADD_CY = 8,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int COL_W  = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             wdata_i,
    input  logic             start_i,
    output logic             sense_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sum_o,
    output logic             carry_o
);
    localparam int LANES = COLS / BPS;
    localparam int LCW   = $clog2(BPS);
    localparam int LAW   = $clog2(LANES);
    localparam int X_LANE = ADD_CX / BPS;
    localparam int Y_LANE = ADD_CY / BPS;

    imc_op_e          seq_op   [LANES];
    logic [ROW_W-1:0] seq_row  [LANES];
    logic [LCW-1:0]   seq_col  [LANES];
    logic             seq_wd   [LANES];
    imc_op_e          lane_op  [LANES];
    logic [ROW_W-1:0] lane_row [LANES];
    logic [LCW-1:0]   lane_col [LANES];
    logic             lane_wd  [LANES];
    imc_ctrl_t        lane_ctrl[LANES];
    logic [ROWS-1:0]  lane_wl  [LANES];
    rd_level_e        lane_lvl [LANES];
    logic [LANES-1:0] set_p, clr_p, raw, sa_d, sa_q;

    logic           ext_take, ext_sense;
    logic [LAW-1:0] ext_lane, last_lane_q;
    imc_op_e        ext_op;

    assign ext_op    = imc_op_e'(op_i);
    assign ext_lane  = col_i[COL_W-1:LCW];
    assign ext_take  = !busy_o && !start_i && (ext_op != OP_NOP);
    assign ext_sense = ext_take && (ext_op inside {OP_READ, OP_NOT, OP_MAJ, OP_NMAJ});

    imc_add_seq #(
        .ROWS(ROWS), .BPS(BPS), .LANES(LANES),
        .X_LANE(X_LANE), .Y_LANE(Y_LANE),
        .X_LOC(ADD_CX % BPS), .Y_LOC(ADD_CY % BPS)
    ) seq_i (
        .clk(clk), .rst(rst), .start(start_i),
        .sa_x_q(sa_q[X_LANE]), .sa_y_q(sa_q[Y_LANE]),
        .sa_x_d(sa_d[X_LANE]), .sa_y_d(sa_d[Y_LANE]),
        .op(seq_op), .row(seq_row), .col(seq_col), .wd(seq_wd),
        .busy(busy_o), .done(done_o), .sum(sum_o), .carry(carry_o)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            if (busy_o) begin
                lane_op[l]  = seq_op[l];
                lane_row[l] = seq_row[l];
                lane_col[l] = seq_col[l];
                lane_wd[l]  = seq_wd[l];
            end else begin
                lane_op[l]  = (ext_take && ext_lane == LAW'(l)) ? ext_op : OP_NOP;
                lane_row[l] = row_i;
                lane_col[l] = col_i[LCW-1:0];
                lane_wd[l]  = wdata_i;
            end
        end

        imc_op_decoder #(.ROWS(ROWS)) dec_i (
            .op(lane_op[l]), .row(lane_row[l]), .wdata(lane_wd[l]),
            .ctrl(lane_ctrl[l]), .wl(lane_wl[l])
        );

        assign set_p[l]    = lane_ctrl[l].bl_pulse;
        assign clr_p[l]    = lane_ctrl[l].sl_pulse;
        assign lane_lvl[l] = lane_ctrl[l].level;

        imc_sense_lane sa_i (
            .clk(clk), .rst(rst), .en(lane_ctrl[l].sense_en),
            .inv(lane_ctrl[l].inv), .raw(raw[l]), .d(sa_d[l]), .q(sa_q[l])
        );
    end

    imc_cell_array #(.ROWS(ROWS), .COLS(COLS), .BPS(BPS)) arr_i (
        .clk(clk), .rst(rst), .wl(lane_wl), .col(lane_col),
        .set_p(set_p), .clr_p(clr_p), .level(lane_lvl), .raw(raw)
    );

    always_ff @(posedge clk) begin
        if (rst)            last_lane_q <= '0;
        else if (ext_sense) last_lane_q <= ext_lane;
    end

    assign sense_o = sa_q[last_lane_q];
endmodule

// File: rtl/imc_majority_ctrl_chk.sv
module imc_majority_ctrl_chk
    import imc_pkg::*;
#(
    parameter int LANES = 2,
    parameter int ROWS  = 16
) (
    input logic             clk,
    input logic             rst,
    input imc_ctrl_t        ctrl [LANES],
    input logic [ROWS-1:0]  wl   [LANES],
    input logic [LANES-1:0] sa_q,
    input logic             busy_o,
    input logic             done_o,
    input logic             start_i
);
    logic [3:0] run;

    always_ff @(posedge clk) begin
        if (rst)         run <= '0;
        else if (busy_o) run <= run + 4'd1;
        else             run <= '0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        a_r1_single_row_read: assert property (@(posedge clk) disable iff (rst)
            (ctrl[l].sense_en && !ctrl[l].maj) |->
                ($countones(wl[l]) == 1 && ctrl[l].level == LVL_FULL));
        a_r2_inv_only_sensing: assert property (@(posedge clk) disable iff (rst)
            ctrl[l].inv |-> ctrl[l].sense_en);
        a_r3_three_rows: assert property (@(posedge clk) disable iff (rst)
            ctrl[l].maj |->
                ($countones(wl[l]) == 3 && ctrl[l].sense_en && ctrl[l].level == LVL_THIRD));
        a_r5_write_shape: assert property (@(posedge clk) disable iff (rst)
            (ctrl[l].bl_pulse || ctrl[l].sl_pulse) |->
                (!ctrl[l].sense_en && !ctrl[l].inv && $countones(wl[l]) == 1));
        a_r5_pulse_excl: assert property (@(posedge clk) disable iff (rst)
            !(ctrl[l].bl_pulse && ctrl[l].sl_pulse));
        a_r6_sense_hold: assert property (@(posedge clk) disable iff (rst)
            !ctrl[l].sense_en |=> $stable(sa_q[l]));
    end

    a_r8_six_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> run == 4'd6);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r8_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);
    a_r9_rise_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind imc_majority_ctrl imc_majority_ctrl_chk #(.LANES(LANES), .ROWS(ROWS)) chk_i (
    .clk(clk), .rst(rst), .ctrl(lane_ctrl), .wl(lane_wl), .sa_q(sa_q),
    .busy_o(busy_o), .done_o(done_o), .start_i(start_i)
);

// File: tb/imc_majority_ctrl_tb_top.sv
`timescale 1ns/1ps
module imc_majority_ctrl_tb_top;
    import imc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = 3'd0;
    logic [3:0] row_i = '0;
    logic [3:0] col_i = '0;
    logic       wdata_i = 1'b0;
    logic       start_i = 1'b0;
    logic       sense_o, busy_o, done_o, sum_o, carry_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic mdl [16][16];

    typedef struct {
        int    due;
        int    sig;
        logic  exp;
        string req;
    } item_t;
    item_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    imc_majority_ctrl dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .row_i(row_i), .col_i(col_i),
        .wdata_i(wdata_i), .start_i(start_i), .sense_o(sense_o),
        .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o), .carry_o(carry_o)
    );

    function automatic logic pick(int s);
        case (s)
            0: return sense_o;
            1: return busy_o;
            2: return done_o;
            3: return sum_o;
            default: return carry_o;
        endcase
    endfunction

    // monitor: compare every queued item in its due cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                checks++;
                if (pick(sbq[i].sig) !== sbq[i].exp) begin
                    errors++;
                    $display("FAIL %s sig%0d actual %b expected %b cycle %0d",
                             sbq[i].req, sbq[i].sig, pick(sbq[i].sig), sbq[i].exp, cyc);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic expect_at(int dly, int sig, logic e, string req);
        item_t it;
        it.due = cyc + dly; it.sig = sig; it.exp = e; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic drive(imc_op_e op, int r, int c, logic wd);
        op_i = op; row_i = 4'(r); col_i = 4'(c); wdata_i = wd;
    endtask

    task automatic wr(int r, int c, logic v, int mode);
        @(negedge clk);
        if (mode == 0)      drive(v ? OP_SET : OP_CLR, r, c, 1'b0);
        else                drive(OP_WRD, r, c, v);
        mdl[r][c] = v;
        @(negedge clk);
        drive(OP_NOP, 0, 0, 1'b0);
    endtask

    task automatic rd(int r, int c, logic inv, string req);
        @(negedge clk);
        drive(inv ? OP_NOT : OP_READ, r, c, 1'b0);
        expect_at(1, 0, mdl[r][c] ^ inv, req);
        @(negedge clk);
        drive(OP_NOP, 0, 0, 1'b0);
    endtask

    task automatic mj(int r, int c, logic inv, string req);
        int n;
        n = int'(mdl[r % 16][c]) + int'(mdl[(r + 1) % 16][c]) + int'(mdl[(r + 2) % 16][c]);
        @(negedge clk);
        drive(inv ? OP_NMAJ : OP_MAJ, r, c, 1'b0);
        expect_at(1, 0, (n >= 2) ^ inv, req);
        @(negedge clk);
        drive(OP_NOP, 0, 0, 1'b0);
    endtask

    task automatic add(logic a, logic b, logic ci, bit poke);
        logic [1:0] s;
        s = 2'(a) + 2'(b) + 2'(ci);
        for (int k = 0; k < 2; k++) begin
            wr(0, k * 8, a, 1);
            wr(1, k * 8, b, 0);
            wr(2, k * 8, ci, 1);
        end
        @(negedge clk);
        start_i = 1'b1;
        if (poke) drive(OP_SET, 6, 4, 1'b0);
        for (int k = 1; k <= 6; k++) expect_at(k, 1, 1'b1, "R8");
        expect_at(7, 1, 1'b0, "R8");
        expect_at(7, 2, 1'b1, "R8");
        expect_at(7, 3, s[0], "R7");
        expect_at(7, 4, s[1], "R7");
        expect_at(8, 2, 1'b0, "R8");
        expect_at(8, 3, s[0], "R8");
        expect_at(8, 4, s[1], "R8");
        @(negedge clk);
        start_i = 1'b0;
        drive(OP_NOP, 0, 0, 1'b0);
        @(negedge clk);
        if (poke) begin
            start_i = 1'b1;
            drive(OP_SET, 5, 3, 1'b0);
        end
        @(negedge clk);
        start_i = 1'b0;
        drive(OP_NOP, 0, 0, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        summary();
    end

    initial begin
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) mdl[r][c] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        for (int s = 0; s < 5; s++) expect_at(1, s, 1'b0, "R10");
        @(negedge clk);
        rd(3, 3, 1'b0, "R10");
        rd(9, 14, 1'b0, "R10");

        // R5 writes by every write opcode, then R1 / R2 reads
        for (int r = 0; r < 8; r++) wr(r, 5, logic'((8'hB2 >> r) & 1), r % 2);
        wr(4, 13, 1'b1, 0);
        wr(4, 13, 1'b0, 1);
        wr(0, 13, 1'b0, 0);
        for (int r = 0; r < 8; r++) rd(r, 5, 1'b0, "R1_R5");
        for (int r = 0; r < 8; r++) rd(r, 5, 1'b1, "R2");
        rd(4, 13, 1'b0, "R5");

        // R3 / R4 every pattern of three cells
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < 3; k++) wr(8 + k, 12, logic'((v >> k) & 1), k % 2);
            mj(8, 12, 1'b0, "R3");
            mj(8, 12, 1'b1, "R4");
        end
        // R3 wrap across the last row
        wr(15, 2, 1'b1, 0);
        wr(0, 2, 1'b0, 0);
        wr(1, 2, 1'b1, 1);
        mj(15, 2, 1'b0, "R3");
        mj(14, 2, 1'b0, "R3");
        mj(15, 2, 1'b1, "R4");

        // R6 hold through writes and idle; lane follows last sense
        rd(1, 5, 1'b0, "R6");
        @(negedge clk);
        drive(OP_CLR, 2, 6, 1'b0);
        mdl[2][6] = 1'b0;
        expect_at(1, 0, 1'b1, "R6");
        expect_at(2, 0, 1'b1, "R6");
        expect_at(3, 0, 1'b1, "R6");
        @(negedge clk);
        drive(OP_NOP, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        rd(0, 13, 1'b0, "R6");
        @(negedge clk);
        expect_at(1, 0, 1'b0, "R6");

        // R7 / R8 / R9 full adder, all combinations
        wr(6, 4, 1'b0, 0);
        wr(5, 3, 1'b0, 0);
        for (int v = 0; v < 8; v++)
            add(logic'(v & 1), logic'((v >> 1) & 1), logic'((v >> 2) & 1), v[0]);
        rd(6, 4, 1'b0, "R9");
        rd(5, 3, 1'b0, "R9");

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual %0d pending expected 0", sbq.size());
        end
        summary();
    end
endmodule